// File: doc/BRIEF.md
# Word-to-Byte Bus Access Splitter

This block bridges a 16-bit host memory-mode bus to an 8-bit local peripheral bus. When splitting is enabled and the host presents a qualifying word access, the block runs two timed byte cycles on the peripheral side, low byte first, then high byte. It holds the host in a wait state until both cycles are over. On reads, the two bytes are joined into one host word. When splitting is off, or the access does not qualify, the host access runs as one timed byte cycle.

Each peripheral byte cycle has two parts. A setup gap comes first, then an active-low strobe. The lengths of both come from 3-bit configuration fields. A peripheral ready line, passed through a two-flop synchronizer, can hold a strobe low past its programmed width. A configuration bit selects how host address lines map onto the 3-bit local address. Another bit sets the level of the byte-high-enable output.

Top module: `word_byte_splitter`

## Requirements
- R1: Reset state. While `rst_n` is low and after it is released, `host_wait` is 0. `per_rd_n` and `per_wr_n` are 1. `per_bhe` equals `cfg_bhe_pol`.
- R2: An access qualifies for splitting when `cfg_split_en`=1, `host_mem_mode`=1, `host_hi_en`=1 and `host_addr[0]`=0. A qualifying access produces exactly two peripheral strobes. The first carries `host_wdata[7:0]`; the second carries `host_wdata[15:8]`. A read strobes `per_rd_n` and a write strobes `per_wr_n`, and the two are never low together.
- R3: A non-qualifying access produces exactly one strobe. For example, `cfg_split_en`=0 or `host_mem_mode`=0 does not qualify. On a write, that strobe carries `host_wdata[7:0]`.
- R4: `host_wait` rises on the cycle after `host_req` is sampled high while idle. It falls on the cycle after the last strobe ends. No strobe is active while `host_wait` is 0.
- R5: Before each strobe, the block inserts a setup gap of `cfg_setup` clock cycles, where a setting of 0 counts as 1. During the gap `host_wait` is high and no strobe is active.
- R6: With `per_ready` high, each strobe is low for exactly `cfg_width` cycles, where a setting of 0 counts as 1.
- R7: `per_ready` passes through a two-flop synchronizer. While its synchronized value is 0, the active strobe stays low past its programmed width. The strobe ends on the third clock edge after `per_ready` rises.
- R8: The local address is built from the host address. With `cfg_addr_div`=1, the local address is `host_addr[3:1]`; with `cfg_addr_div`=0, it is `host_addr[2:0]`. The second strobe of a split uses that address with bit 0 forced to 1.
- R9: The high-byte enable is active in two cases: during the second byte of a split, and during a single cycle whose `host_hi_en` is 1. `per_bhe` equals that active state XOR `cfg_bhe_pol`, so the output is active high when the bit is 0 and active low when it is 1.
- R10: `host_rdata` is updated when `host_wait` falls after a read. A split read returns {second byte, first byte}. A single read returns {8'h00, byte}.
- R11: `host_req` is ignored while `host_wait` is 1. It starts no strobe and does not change the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_split_en | input | 1 | Word-to-byte split enable |
| cfg_bhe_pol | input | 1 | High-byte-enable polarity (0 = active high) |
| cfg_addr_div | input | 1 | Shift host address right by one for the local address |
| cfg_setup | input | 3 | Setup gap before each strobe, in cycles (0 counts as 1) |
| cfg_width | input | 3 | Strobe width in cycles (0 counts as 1) |
| host_mem_mode | input | 1 | Host bus is in memory mode |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_hi_en | input | 1 | Host high-byte card enable asserted |
| host_addr | input | 4 | Host address |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word |
| host_wait | output | 1 | Host wait state |
| per_addr | output | 3 | Local peripheral address |
| per_wdata | output | 8 | Local write byte |
| per_rdata | input | 8 | Local read byte |
| per_rd_n | output | 1 | Local read strobe, active low |
| per_wr_n | output | 1 | Local write strobe, active low |
| per_bhe | output | 1 | High-byte enable with programmed polarity |
| per_ready | input | 1 | Peripheral ready; low stretches the strobe |

## Verification
The bench targets these corner cases, each with the failure it would expose:

- **Zero timing fields.** A design that took 0 literally would emit a zero-length strobe or skip the setup gap.
- **Splitting with address division on.** If bit 0 were not forced, both bytes would land on the same local address.
- **Polarity set to active low.** The enable level would come out inverted.
- **Ready held low into a strobe.** With one synchronizer stage too few or too many, the strobe would end a cycle early or late.
- **Request pulsed mid-transaction.** A block that did not ignore it would emit an extra strobe or corrupt the latched address.
- **Split read.** A design with the byte order swapped would return the wrong word.

// File: rtl/wbs_pkg.sv
// Shared definitions for the word-to-byte splitter.
// Assumes the timing fields are three bits wide and counted in core clocks.
package wbs_pkg;
    parameter int WBS_TW = 3;
    typedef logic [WBS_TW-1:0] tick_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2
    } phase_t;
endpackage

// File: rtl/wbs_ready_sync.sv
// Multi-stage synchronizer for the peripheral ready line.
// Assumes the line is asynchronous to clk. Resets to "ready" so that the
// first access after reset is not stretched.
module wbs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: capture the raw line once per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_multi
            // Shift the raw line through the chain, one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/wbs_addr_map.sv
// Host-to-local address mapping.
// Assumes the host address is one bit wider than the local one. With divide
// selected, the host address is shifted right by one. The second byte of a
// split gets bit 0 forced high.
module wbs_addr_map #(
    parameter int LOC_AW  = 3,
    localparam int HOST_AW = LOC_AW + 1
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               divide,
    input  logic               odd_byte,
    output logic [LOC_AW-1:0]  loc_addr
);
    logic [LOC_AW-1:0] base;

    // Choose which window of host lines reaches the local bus.
    always_comb begin
        if (divide) base = host_addr[LOC_AW:1];
        else        base = host_addr[LOC_AW-1:0];
    end

    // Second byte of a split always lands on the odd local address.
    always_comb begin
        loc_addr = base;
        if (odd_byte) loc_addr[0] = 1'b1;
    end
endmodule

// File: rtl/wbs_sequencer.sv
// Byte-cycle sequencer: setup gap, then strobe, repeated once more for a
// split access.
// Assumes: start is only raised while idle; the timing fields are stable
// while busy; rdy is already synchronized.
module wbs_sequencer
    import wbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   split_in,
    input  tick_t  setup_len,
    input  tick_t  strobe_len,
    input  logic   rdy,
    output phase_t phase,
    output logic   byte_sel,
    output logic   split_act,
    output logic   byte_done,
    output logic   last_done,
    output logic   busy
);
    tick_t cnt;
    tick_t setup_last;
    tick_t strobe_last;
    logic  strobe_end;

    function automatic tick_t at_least_one(input tick_t f);
        return (f == '0) ? tick_t'(1) : f;
    endfunction

    // Terminal counts; a zero field behaves as one cycle.
    always_comb begin
        setup_last  = at_least_one(setup_len) - tick_t'(1);
        strobe_last = at_least_one(strobe_len) - tick_t'(1);
    end

    // The strobe ends once the width has elapsed and the peripheral is ready.
    always_comb begin
        strobe_end = (phase == PH_STROBE) && (cnt >= strobe_last) && rdy;
        byte_done  = strobe_end;
        last_done  = strobe_end && (byte_sel || !split_act);
        busy       = (phase != PH_IDLE);
    end

    // Phase, counter and byte-index state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            byte_sel  <= 1'b0;
            split_act <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_SETUP;
                        cnt       <= '0;
                        byte_sel  <= 1'b0;
                        split_act <= split_in;
                    end
                end
                PH_SETUP: begin
                    if (cnt == setup_last) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + tick_t'(1);
                    end
                end
                PH_STROBE: begin
                    if (strobe_end) begin
                        cnt <= '0;
                        if (split_act && !byte_sel) begin
                            phase    <= PH_SETUP;
                            byte_sel <= 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else if (cnt < strobe_last) begin
                        cnt <= cnt + tick_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // A low synchronized ready keeps the strobe phase.
    assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE && !rdy) |=> (phase == PH_STROBE));

    // A strobe never follows idle directly: a setup gap always comes first.
    assert_gap_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE) |-> ($past(phase) != PH_IDLE));
endmodule

// File: rtl/word_byte_splitter.sv
// Top of the word-to-byte bus splitter.
// Latches a host access, decides whether it splits, drives the local strobes,
// address, data and high-byte enable, and assembles read words.
// Assumes host_req is a one-cycle pulse and that configuration inputs are
// stable while host_wait is high.
module word_byte_splitter
    import wbs_pkg::*;
#(
    parameter int  DW      = 8,
    parameter int  LOC_AW  = 3,
    parameter int  SYNC_ST = 2,
    localparam int HOST_AW = LOC_AW + 1,
    localparam int HDW     = 2 * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_split_en,
    input  logic               cfg_bhe_pol,
    input  logic               cfg_addr_div,
    input  logic [WBS_TW-1:0]  cfg_setup,
    input  logic [WBS_TW-1:0]  cfg_width,
    input  logic               host_mem_mode,
    input  logic               host_req,
    input  logic               host_we,
    input  logic               host_hi_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HDW-1:0]     host_wdata,
    output logic [HDW-1:0]     host_rdata,
    output logic               host_wait,
    output logic [LOC_AW-1:0]  per_addr,
    output logic [DW-1:0]      per_wdata,
    input  logic [DW-1:0]      per_rdata,
    output logic               per_rd_n,
    output logic               per_wr_n,
    output logic               per_bhe,
    input  logic               per_ready
);
    logic               start;
    logic               split_req;
    logic               we_q, hi_q, div_q;
    logic [HOST_AW-1:0] addr_q;
    logic [HDW-1:0]     wdata_q;
    tick_t              setup_q, width_q;
    logic [DW-1:0]      lo_q;
    logic [HDW-1:0]     rdata_q;
    logic               rdy_s;
    phase_t             phase;
    logic               byte_sel, split_act, byte_done, last_done, busy;
    logic               strobe_on, bhe_act;

    // Accept a request only while idle; decide here whether it splits.
    always_comb begin
        start     = host_req && !busy;
        split_req = cfg_split_en && host_mem_mode && host_hi_en && !host_addr[0];
    end

    // Capture the host access and timing fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            hi_q    <= 1'b0;
            div_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            setup_q <= '0;
            width_q <= '0;
        end else if (start) begin
            we_q    <= host_we;
            hi_q    <= host_hi_en;
            div_q   <= cfg_addr_div;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            setup_q <= cfg_setup;
            width_q <= cfg_width;
        end
    end

    wbs_ready_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (per_ready),
        .dout  (rdy_s)
    );

    wbs_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .split_in   (split_req),
        .setup_len  (setup_q),
        .strobe_len (width_q),
        .rdy        (rdy_s),
        .phase      (phase),
        .byte_sel   (byte_sel),
        .split_act  (split_act),
        .byte_done  (byte_done),
        .last_done  (last_done),
        .busy       (busy)
    );

    wbs_addr_map #(.LOC_AW(LOC_AW)) u_map (
        .host_addr (addr_q),
        .divide    (div_q),
        .odd_byte  (byte_sel),
        .loc_addr  (per_addr)
    );

    // Capture the first byte of a read and assemble the word at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            rdata_q <= '0;
        end else if (byte_done && !we_q) begin
            if (!byte_sel) lo_q <= per_rdata;
            if (last_done) begin
                if (split_act) rdata_q <= {per_rdata, lo_q};
                else           rdata_q <= {{DW{1'b0}}, per_rdata};
            end
        end
    end

    // Drive the local strobes, write byte and high-byte enable.
    always_comb begin
        strobe_on = (phase == PH_STROBE);
        per_wr_n  = !(strobe_on && we_q);
        per_rd_n  = !(strobe_on && !we_q);
        per_wdata = byte_sel ? wdata_q[HDW-1:DW] : wdata_q[DW-1:0];
        bhe_act   = busy && (split_act ? byte_sel : hi_q);
        per_bhe   = bhe_act ^ cfg_bhe_pol;
    end

    assign host_wait  = busy;
    assign host_rdata = rdata_q;

    // Never both strobes at once.
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!per_rd_n && !per_wr_n));

    // No strobe while the host is not held.
    assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wait |-> (per_rd_n && per_wr_n));

    // Second byte of a split always goes to an odd local address.
    assert_odd_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (split_act && byte_sel && !(per_rd_n && per_wr_n)) |-> per_addr[0]);

    // High-byte enable sits at its inactive level when idle.
    assert_bhe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wait |-> (per_bhe == cfg_bhe_pol));

    // A request during a busy access leaves the latched address untouched.
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait && host_req) |=> $stable(addr_q));
endmodule

// File: tb/test_word_byte_splitter.sv
`timescale 1ns/1ps
module test_word_byte_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_split_en = 0, cfg_bhe_pol = 0, cfg_addr_div = 0;
    logic [2:0]  cfg_setup = 0, cfg_width = 0;
    logic        host_mem_mode = 1, host_req = 0, host_we = 0, host_hi_en = 0;
    logic [3:0]  host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        host_wait;
    logic [2:0]  per_addr;
    logic [7:0]  per_wdata;
    logic [7:0]  per_rdata;
    logic        per_rd_n, per_wr_n, per_bhe;
    logic        per_ready = 1'b1;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    word_byte_splitter i_word_byte_splitter (
        .clk(clk), .rst_n(rst_n), .cfg_split_en(cfg_split_en), .cfg_bhe_pol(cfg_bhe_pol),
        .cfg_addr_div(cfg_addr_div), .cfg_setup(cfg_setup), .cfg_width(cfg_width),
        .host_mem_mode(host_mem_mode), .host_req(host_req), .host_we(host_we),
        .host_hi_en(host_hi_en), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_wait(host_wait), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_rd_n(per_rd_n),
        .per_wr_n(per_wr_n), .per_bhe(per_bhe), .per_ready(per_ready)
    );

    // Peripheral model: eight byte registers.
    logic [7:0] pmem [8];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) pmem[i] <= 8'(i * 17 + 3);
        end else if (!per_wr_n) begin
            pmem[per_addr] <= per_wdata;
        end
    end
    assign per_rdata = pmem[per_addr];

    typedef struct {
        logic [2:0] addr;
        logic [7:0] data;
        bit         we;
        bit         bhe;
        int         len;
        int         gap;
    } item_t;
    item_t expq[$];

    task automatic check(input bit ok, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Monitor: measure each strobe and compare it with the next expected item.
    bit         in_st = 0;
    int         gap_cnt = 0, len_cnt = 0, gap_seen = 0;
    item_t      cur;
    always @(negedge clk) begin
        if (rst_n) begin
            bit st;
            st = !per_rd_n || !per_wr_n;
            if (st && !in_st) begin
                in_st = 1;
                len_cnt = 1;
                gap_seen = gap_cnt;
                gap_cnt = 0;
                cur.addr = per_addr; cur.data = per_wdata; cur.we = !per_wr_n; cur.bhe = per_bhe;
            end else if (st) begin
                len_cnt++;
            end else begin
                if (in_st) begin
                    in_st = 0;
                    cur.len = len_cnt; cur.gap = gap_seen;
                    if (expq.size() == 0) begin
                        check(0, "R3 R11 unexpected strobe at addr", int'(cur.addr), -1);
                    end else begin
                        item_t e;
                        bit ok;
                        e = expq.pop_front();
                        ok = (e.addr == cur.addr) && (e.we == cur.we) && (e.bhe == cur.bhe) &&
                             (e.len == cur.len) && (e.gap == cur.gap) && (!e.we || e.data == cur.data);
                        if (!ok)
                            $display("  strobe detail (act/exp): addr %0h/%0h we %0d/%0d bhe %0d/%0d len %0d/%0d gap %0d/%0d data %0h/%0h",
                                     cur.addr, e.addr, cur.we, e.we, cur.bhe, e.bhe, cur.len, e.len,
                                     cur.gap, e.gap, cur.data, e.data);
                        check(ok, "R2 R5 R6 R7 R8 R9 strobe item addr", int'(cur.addr), int'(e.addr));
                    end
                end
                if (host_wait) gap_cnt++;
                else           gap_cnt = 0;
            end
        end
    end

    function automatic int eff(input int f);
        return (f == 0) ? 1 : f;
    endfunction

    // Driver: push expected strobes, run the access, check wait length and read data.
    task automatic access(input bit we, input logic [3:0] a, input logic [15:0] wd,
                          input bit hi, input bit sen, input bit mm, input bit dv,
                          input bit pol, input int d, input int w,
                          input bit stretch, input bit inject);
        bit split;
        logic [2:0] m;
        item_t e0, e1;
        int exp_wait, wait_cnt;
        logic [15:0] exp_rd;
        split = sen && mm && hi && !a[0];
        m = dv ? a[3:1] : a[2:0];
        e0.addr = m; e0.data = wd[7:0]; e0.we = we; e0.bhe = (split ? 1'b0 : hi) ^ pol;
        e0.len = stretch ? 8 : eff(w); e0.gap = eff(d);
        e1.addr = m | 3'd1; e1.data = wd[15:8]; e1.we = we; e1.bhe = 1'b1 ^ pol;
        e1.len = eff(w); e1.gap = eff(d);
        expq.push_back(e0);
        exp_wait = e0.len + e0.gap;
        if (split) begin
            expq.push_back(e1);
            exp_wait += e1.len + e1.gap;
        end
        exp_rd = split ? {pmem[m | 3'd1], pmem[m]} : {8'h00, pmem[m]};
        @(negedge clk);
        cfg_split_en = sen; cfg_bhe_pol = pol; cfg_addr_div = dv;
        cfg_setup = 3'(d); cfg_width = 3'(w);
        host_mem_mode = mm; host_we = we; host_hi_en = hi; host_addr = a; host_wdata = wd;
        if (stretch) per_ready = 1'b0;
        host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        wait_cnt = 0;
        fork
            begin
                while (host_wait) begin
                    wait_cnt++;
                    @(negedge clk);
                end
            end
            begin
                if (inject) begin
                    @(negedge clk);
                    host_req = 1'b1; host_addr = 4'h9; host_we = ~we; host_wdata = 16'hFFFF;
                    @(negedge clk);
                    host_req = 1'b0;
                end
            end
            begin
                if (stretch) begin
                    int lowc = 0;
                    while (lowc < 6) begin
                        @(negedge clk);
                        if (!per_rd_n || !per_wr_n) lowc++;
                    end
                    per_ready = 1'b1;
                end
            end
        join
        check(wait_cnt == exp_wait, "R4 wait duration", wait_cnt, exp_wait);
        if (!we) check(host_rdata == exp_rd, "R10 read word", int'(host_rdata), int'(exp_rd));
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, still in reset and after release.
        check(host_wait == 1'b0, "R1 wait in reset", int'(host_wait), 0);
        check(per_rd_n && per_wr_n, "R1 strobes idle in reset", int'({per_rd_n, per_wr_n}), 3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(per_bhe == cfg_bhe_pol, "R1 bhe inactive", int'(per_bhe), int'(cfg_bhe_pol));
        check(host_wait == 1'b0, "R1 wait after reset", int'(host_wait), 0);

        // R2 R5 R6: split write with zero fields (treated as one).
        access(1, 4'h4, 16'hB7A5, 1, 1, 1, 0, 0, 0, 0, 0, 0);
        // R10: split read back of the same word.
        access(0, 4'h4, 16'h0000, 1, 1, 1, 0, 0, 0, 0, 0, 0);
        // R8: address divide, longer setup and width.
        access(1, 4'hC, 16'h5A3C, 1, 1, 1, 1, 0, 3, 5, 0, 0);
        access(0, 4'hC, 16'h0000, 1, 1, 1, 1, 0, 2, 4, 0, 0);
        // R3: split disabled passes one byte through.
        access(1, 4'h2, 16'hEE61, 1, 0, 1, 0, 0, 1, 2, 0, 0);
        access(0, 4'h2, 16'h0000, 1, 0, 1, 0, 0, 1, 2, 0, 0);
        // R3: not memory mode, no split; high enable low.
        access(1, 4'h0, 16'h9911, 0, 1, 0, 0, 0, 2, 1, 0, 0);
        // R9: active-low polarity on a split write.
        access(1, 4'h6, 16'hC4D2, 1, 1, 1, 0, 1, 1, 3, 0, 0);
        access(0, 4'h6, 16'h0000, 1, 1, 1, 0, 1, 7, 7, 0, 0);
        // R7: ready held low stretches the first strobe of a split read.
        access(0, 4'h2, 16'h0000, 1, 1, 1, 0, 0, 2, 1, 1, 0);
        // R11: request pulsed mid-access is ignored.
        access(1, 4'h4, 16'h1234, 1, 1, 1, 0, 0, 3, 2, 0, 1);
        access(0, 4'h4, 16'h0000, 1, 1, 1, 0, 0, 1, 1, 0, 0);
        // R3: odd host address does not split.
        access(0, 4'h5, 16'h0000, 1, 1, 1, 0, 0, 1, 1, 0, 0);

        repeat (10) @(negedge clk);
        check(expq.size() == 0, "R2 R3 missing strobes", expq.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog: run did not complete (R4 wait stuck?) actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule